// File: doc/BRIEF.md
# SDRAM Host Controller with Periodic Refresh

This block sits between a simple request port and a four-bank SDRAM with 12-bit row and 9-bit column addresses. Each request names a bank, row, column and direction. For a write it also carries one data byte. The controller opens the row and issues a single-beat read or write that closes the row on its own (auto-precharge). It then waits out the recovery time before it takes the next request. Read data comes back on a response strobe a fixed number of clocks after the read command.

After reset the block runs a fixed power-up order. It waits, precharges every bank, issues two auto-refreshes, and then loads the mode word (CAS latency 2, burst length 1, sequential). Only after that does it accept traffic. A free-running refresh timer then requests one auto-refresh per interval. A pending refresh outranks new requests. It is served once the current access has finished its recovery, and it is always preceded by a precharge of every bank. All bank timings are given in nanoseconds and rounded up to whole clocks from the clock period parameter.

Top module: `sdram_host_ctrl`

## Requirements
- R1: While reset is held, req_ready_o is 0, sd_cke_o is 0, sd_cs_n_o is 1, sd_dqm_o is 1 and sd_dq_oe_o is 0.
- R2: After reset the command order is: at least INIT_CYC idle clocks, PRECHARGE with A10=1, AUTO REFRESH, AUTO REFRESH, MODE SET with A=12'h020 (CAS latency 2 in A[6:4], burst length 1 in A[2:0]). The gaps are at least tRP, tRFC, tRFC and 2 clocks. req_ready_o stays 0 until this order is complete.
- R3: An accepted request produces ACTIVATE (bank on BA, row on A), then exactly tRCD clocks later READ or WRITE on the same bank, with the column on A[8:0] and A10=1.
- R4: Back-to-back requests are accepted exactly 9 clocks apart at 125 MHz. Every ACTIVATE respects tRC from the previous ACTIVATE and tRP after the auto-precharge start, which is the later of one clock after the command and tRAS after ACTIVATE.
- R5: Write data is on sd_dq_o with sd_dq_oe_o=1 in the same clock as the WRITE command. sd_dq_oe_o is 0 in every other clock.
- R6: For a read accepted at edge N, rsp_valid_o is 1 for exactly one cycle after edge N+6, and rsp_rdata_o holds the byte last written to that bank, row and column.
- R7: After initialization, an AUTO REFRESH appears at least once every REF_INTERVAL+20 clocks. Each one comes exactly tRP after a PRECHARGE with A10=1, while no row is open, and at least tRFC after the previous refresh.
- R8: While a refresh is pending, req_ready_o is 0. Under a continuous request stream refreshes still occur, and no ACTIVATE is issued between a refresh's precharge-all and its AUTO REFRESH.
- R9: req_ready_o drops in the cycle after a request is accepted, so one request is taken per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted when both are high |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_bank_i | input | 2 | Bank number |
| req_row_i | input | 12 | Row address |
| req_col_i | input | 9 | Column address |
| req_wdata_i | input | 8 | Write byte |
| rsp_valid_o | output | 1 | Read data strobe |
| rsp_rdata_o | output | 8 | Read data |
| sd_cke_o | output | 1 | Clock enable to memory |
| sd_cs_n_o | output | 1 | Chip select, low active |
| sd_ras_n_o | output | 1 | Row strobe, low active |
| sd_cas_n_o | output | 1 | Column strobe, low active |
| sd_we_n_o | output | 1 | Write enable, low active |
| sd_ba_o | output | 2 | Bank address |
| sd_a_o | output | 12 | Multiplexed address |
| sd_dqm_o | output | 1 | Data mask |
| sd_dq_o | output | 8 | Data to memory |
| sd_dq_oe_o | output | 1 | Data output enable |
| sd_dq_i | input | 8 | Data from memory |

## Verification
A wrong wait count or state shows up at once on the command pins. A gap between ACTIVATE and the column command, between two ACTIVATEs, or between a precharge and a refresh becomes shorter than the rounded-up minimum, and a bus model that timestamps every command flags it at that command. A fault in the read pipe shifts rsp_valid_o off edge N+6 or returns a byte from another location, which shows on the first read. A fault in the refresh timer or in refresh priority shows within one refresh interval, either as an over-long gap between refreshes or as an ACTIVATE slipped between the precharge-all and the refresh.

// File: rtl/sdrc_pkg.sv
package sdrc_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS   = 4'b0000,
    CMD_REF   = 4'b0001,
    CMD_PRE   = 4'b0010,
    CMD_ACT   = 4'b0011,
    CMD_WR    = 4'b0100,
    CMD_RD    = 4'b0101,
    CMD_NOP   = 4'b0111,
    CMD_DESEL = 4'b1111
  } sdram_cmd_e;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_BOOT_REF,
    ST_BOOT_MRS,
    ST_IDLE,
    ST_ACCESS,
    ST_REF
  } seq_state_e;

  function automatic int ns_to_cyc(input int ns, input int period_ps);
    return (ns * 1000 + period_ps - 1) / period_ps;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdrc_refresh_timer.sv
module sdrc_refresh_timer #(
  parameter int REF_INTERVAL = 1953,
  parameter int PEND_MAX     = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ack_i,
  output logic pending_o
);
  localparam int CNT_W  = $clog2(REF_INTERVAL + 1);
  localparam int PEND_W = $clog2(PEND_MAX + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [PEND_W-1:0] pend_q;
  logic              tick;

  assign tick = en_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CNT_W'(REF_INTERVAL - 1);
    end else if (en_i) begin
      cnt_q <= tick ? CNT_W'(REF_INTERVAL - 1) : cnt_q - 1'b1;
    end
  end

  // saturates: an overdue interval leaves two refreshes owed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
    end else begin
      unique case ({tick, ack_i})
        2'b10:   if (pend_q != PEND_W'(PEND_MAX)) pend_q <= pend_q + 1'b1;
        2'b01:   pend_q <= pend_q - 1'b1;
        default: pend_q <= pend_q;
      endcase
    end
  end

  assign pending_o = (pend_q != '0);

  a_r7_ack_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |-> pending_o);

  a_r7_pending_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q <= PEND_W'(PEND_MAX));

endmodule

// File: rtl/sdrc_sequencer.sv
module sdrc_sequencer
  import sdrc_pkg::*;
#(
  parameter int BANK_W        = 2,
  parameter int ROW_W         = 12,
  parameter int COL_W         = 9,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_PS = 8000,
  parameter int T_RCD_NS      = 20,
  parameter int T_RP_NS       = 20,
  parameter int T_RAS_NS      = 45,
  parameter int T_RC_NS       = 65,
  parameter int T_RFC_NS      = 65,
  parameter int T_RDL_CYC     = 1,
  parameter int T_MRD_CYC     = 2,
  parameter int CAS_LAT       = 2,
  parameter int INIT_CYC      = 25000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              ref_pend_i,
  output logic              ref_ack_o,
  output logic              init_done_o,
  output sdram_cmd_e        cmd_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ROW_W-1:0]  a_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              wdata_oe_o,
  output logic              rd_issue_o
);
  localparam int AP_BIT = 10;
  localparam int TRCD   = ns_to_cyc(T_RCD_NS, CLK_PERIOD_PS);
  localparam int TRP    = ns_to_cyc(T_RP_NS,  CLK_PERIOD_PS);
  localparam int TRAS   = ns_to_cyc(T_RAS_NS, CLK_PERIOD_PS);
  localparam int TRC    = ns_to_cyc(T_RC_NS,  CLK_PERIOD_PS);
  localparam int TRFC   = ns_to_cyc(T_RFC_NS, CLK_PERIOD_PS);
  // column command to next command: auto-precharge start plus tRP, and tRC
  localparam int REC_AP = imax(TRAS - TRCD, 1 + T_RDL_CYC) + TRP;
  localparam int T_RECV = imax(REC_AP, TRC - TRCD);
  localparam int MAX_GAP = imax(imax(imax(TRCD, TRP), imax(TRFC, T_RECV)), T_MRD_CYC);
  localparam int WAIT_W = $clog2(imax(INIT_CYC, MAX_GAP) + 1);
  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT << 4);

  seq_state_e        state_q, state_d;
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic              boot_ref_q, boot_ref_d;
  logic              init_done_q, init_done_d;
  logic              accept;

  logic              rq_wr_q;
  logic [BANK_W-1:0] rq_bank_q;
  logic [ROW_W-1:0]  rq_row_q;
  logic [COL_W-1:0]  rq_col_q;
  logic [DATA_W-1:0] rq_data_q;

  assign req_ready_o = (state_q == ST_IDLE) && (wait_q == '0) && !ref_pend_i;
  assign accept      = req_ready_o && req_valid_i;
  assign init_done_o = init_done_q;

  always_comb begin
    state_d     = state_q;
    wait_d      = wait_q;
    boot_ref_d  = boot_ref_q;
    init_done_d = init_done_q;
    cmd_o       = CMD_NOP;
    ba_o        = '0;
    a_o         = '0;
    wdata_o     = '0;
    wdata_oe_o  = 1'b0;
    rd_issue_o  = 1'b0;
    ref_ack_o   = 1'b0;
    if (wait_q != '0) begin
      wait_d = wait_q - 1'b1;
    end else begin
      unique case (state_q)
        ST_BOOT: begin
          cmd_o          = CMD_PRE;
          a_o[AP_BIT]    = 1'b1;
          wait_d         = WAIT_W'(TRP - 1);
          state_d        = ST_BOOT_REF;
        end
        ST_BOOT_REF: begin
          cmd_o      = CMD_REF;
          wait_d     = WAIT_W'(TRFC - 1);
          boot_ref_d = 1'b1;
          if (boot_ref_q) state_d = ST_BOOT_MRS;
        end
        ST_BOOT_MRS: begin
          cmd_o       = CMD_MRS;
          a_o         = MODE_WORD;
          wait_d      = WAIT_W'(T_MRD_CYC - 1);
          init_done_d = 1'b1;
          state_d     = ST_IDLE;
        end
        ST_IDLE: begin
          if (ref_pend_i) begin
            cmd_o       = CMD_PRE;
            a_o[AP_BIT] = 1'b1;
            wait_d      = WAIT_W'(TRP - 1);
            state_d     = ST_REF;
          end else if (req_valid_i) begin
            cmd_o   = CMD_ACT;
            ba_o    = req_bank_i;
            a_o     = req_row_i;
            wait_d  = WAIT_W'(TRCD - 1);
            state_d = ST_ACCESS;
          end
        end
        ST_ACCESS: begin
          cmd_o       = rq_wr_q ? CMD_WR : CMD_RD;
          ba_o        = rq_bank_q;
          a_o         = ROW_W'(rq_col_q);
          a_o[AP_BIT] = 1'b1;
          wdata_o     = rq_data_q;
          wdata_oe_o  = rq_wr_q;
          rd_issue_o  = !rq_wr_q;
          wait_d      = WAIT_W'(T_RECV - 1);
          state_d     = ST_IDLE;
        end
        ST_REF: begin
          cmd_o     = CMD_REF;
          ref_ack_o = 1'b1;
          wait_d    = WAIT_W'(TRFC - 1);
          state_d   = ST_IDLE;
        end
        default: state_d = ST_BOOT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_BOOT;
      wait_q      <= WAIT_W'(INIT_CYC);
      boot_ref_q  <= 1'b0;
      init_done_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      wait_q      <= wait_d;
      boot_ref_q  <= boot_ref_d;
      init_done_q <= init_done_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rq_wr_q   <= 1'b0;
      rq_bank_q <= '0;
      rq_row_q  <= '0;
      rq_col_q  <= '0;
      rq_data_q <= '0;
    end else if (accept) begin
      rq_wr_q   <= req_write_i;
      rq_bank_q <= req_bank_i;
      rq_row_q  <= req_row_i;
      rq_col_q  <= req_col_i;
      rq_data_q <= req_wdata_i;
    end
  end

  a_r9_one_per_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !req_ready_o);

  a_r8_refresh_blocks_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_pend_i |-> !req_ready_o);

  a_r2_ready_after_boot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> init_done_q);

  a_r3_column_after_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (state_q == ST_ACCESS));

endmodule

// File: rtl/sdrc_pin_stage.sv
module sdrc_pin_stage
  import sdrc_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sdram_cmd_e        cmd_i,
  input  logic [BANK_W-1:0] ba_i,
  input  logic [ROW_W-1:0]  a_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wdata_oe_i,
  input  logic              init_done_i,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ROW_W-1:0]  a_o,
  output logic              dqm_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  localparam int AP_BIT = 10;

  logic [3:0] cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_o   <= 1'b0;
      cmd_q   <= CMD_DESEL;
      ba_o    <= '0;
      a_o     <= '0;
      dqm_o   <= 1'b1;
      dq_o    <= '0;
      dq_oe_o <= 1'b0;
    end else begin
      cke_o   <= 1'b1;
      cmd_q   <= cmd_i;
      ba_o    <= ba_i;
      a_o     <= a_i;
      dqm_o   <= !init_done_i;
      dq_o    <= wdata_i;
      dq_oe_o <= wdata_oe_i;
    end
  end

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd_q;

  a_r5_drive_only_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == CMD_WR));

  a_r3_column_autoprecharge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_o && ras_n_o && !cas_n_o) |-> a_o[AP_BIT]);

endmodule

// File: rtl/sdrc_read_capture.sv
module sdrc_read_capture #(
  parameter int CAS_LAT = 2,
  parameter int DATA_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_issue_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o
);
  // stage 0 lines up with the command pin register
  logic [CAS_LAT:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q   <= '0;
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      pipe_q   <= {pipe_q[CAS_LAT-1:0], rd_issue_i};
      rvalid_o <= pipe_q[CAS_LAT];
      if (pipe_q[CAS_LAT]) rdata_o <= dq_i;
    end
  end

  a_r6_single_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

endmodule

// File: rtl/sdram_host_ctrl.sv
module sdram_host_ctrl
  import sdrc_pkg::*;
#(
  parameter int BANK_W        = 2,
  parameter int ROW_W         = 12,
  parameter int COL_W         = 9,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_PS = 8000,
  parameter int T_RCD_NS      = 20,
  parameter int T_RP_NS       = 20,
  parameter int T_RAS_NS      = 45,
  parameter int T_RC_NS       = 65,
  parameter int T_RFC_NS      = 65,
  parameter int T_RDL_CYC     = 1,
  parameter int T_MRD_CYC     = 2,
  parameter int CAS_LAT       = 2,
  parameter int REF_INTERVAL  = 1953,
  parameter int INIT_CYC      = 25000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              sd_cke_o,
  output logic              sd_cs_n_o,
  output logic              sd_ras_n_o,
  output logic              sd_cas_n_o,
  output logic              sd_we_n_o,
  output logic [BANK_W-1:0] sd_ba_o,
  output logic [ROW_W-1:0]  sd_a_o,
  output logic              sd_dqm_o,
  output logic [DATA_W-1:0] sd_dq_o,
  output logic              sd_dq_oe_o,
  input  logic [DATA_W-1:0] sd_dq_i
);
  sdram_cmd_e        cmd;
  logic [BANK_W-1:0] ba;
  logic [ROW_W-1:0]  addr;
  logic [DATA_W-1:0] wdata;
  logic              wdata_oe, rd_issue, ref_pend, ref_ack, init_done;

  sdrc_refresh_timer #(
    .REF_INTERVAL (REF_INTERVAL),
    .PEND_MAX     (2)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (init_done),
    .ack_i     (ref_ack),
    .pending_o (ref_pend)
  );

  sdrc_sequencer #(
    .BANK_W        (BANK_W),
    .ROW_W         (ROW_W),
    .COL_W         (COL_W),
    .DATA_W        (DATA_W),
    .CLK_PERIOD_PS (CLK_PERIOD_PS),
    .T_RCD_NS      (T_RCD_NS),
    .T_RP_NS       (T_RP_NS),
    .T_RAS_NS      (T_RAS_NS),
    .T_RC_NS       (T_RC_NS),
    .T_RFC_NS      (T_RFC_NS),
    .T_RDL_CYC     (T_RDL_CYC),
    .T_MRD_CYC     (T_MRD_CYC),
    .CAS_LAT       (CAS_LAT),
    .INIT_CYC      (INIT_CYC)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_write_i (req_write_i),
    .req_bank_i  (req_bank_i),
    .req_row_i   (req_row_i),
    .req_col_i   (req_col_i),
    .req_wdata_i (req_wdata_i),
    .ref_pend_i  (ref_pend),
    .ref_ack_o   (ref_ack),
    .init_done_o (init_done),
    .cmd_o       (cmd),
    .ba_o        (ba),
    .a_o         (addr),
    .wdata_o     (wdata),
    .wdata_oe_o  (wdata_oe),
    .rd_issue_o  (rd_issue)
  );

  sdrc_pin_stage #(
    .BANK_W (BANK_W),
    .ROW_W  (ROW_W),
    .DATA_W (DATA_W)
  ) u_pins (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_i       (cmd),
    .ba_i        (ba),
    .a_i         (addr),
    .wdata_i     (wdata),
    .wdata_oe_i  (wdata_oe),
    .init_done_i (init_done),
    .cke_o       (sd_cke_o),
    .cs_n_o      (sd_cs_n_o),
    .ras_n_o     (sd_ras_n_o),
    .cas_n_o     (sd_cas_n_o),
    .we_n_o      (sd_we_n_o),
    .ba_o        (sd_ba_o),
    .a_o         (sd_a_o),
    .dqm_o       (sd_dqm_o),
    .dq_o        (sd_dq_o),
    .dq_oe_o     (sd_dq_oe_o)
  );

  sdrc_read_capture #(
    .CAS_LAT (CAS_LAT),
    .DATA_W  (DATA_W)
  ) u_rdcap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_issue_i (rd_issue),
    .dq_i       (sd_dq_i),
    .rvalid_o   (rsp_valid_o),
    .rdata_o    (rsp_rdata_o)
  );

endmodule

// File: tb/sdram_host_ctrl_test.sv
module sdram_host_ctrl_test;
  localparam int INIT = 40;
  localparam int REFI = 400;
  localparam int TRCD = 3, TRP = 3, TRAS = 6, TRC = 9, TRFC = 9, TMRD = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_bank = '0;
  logic [11:0] req_row = '0;
  logic [8:0]  req_col = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        cke, cs_n, ras_n, cas_n, we_n, dqm, dq_oe;
  logic [1:0]  ba;
  logic [11:0] a;
  logic [7:0]  dq_out;
  logic [7:0]  dq_drv = '0;

  sdram_host_ctrl #(.INIT_CYC(INIT), .REF_INTERVAL(REFI)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_bank_i(req_bank), .req_row_i(req_row), .req_col_i(req_col),
    .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .sd_cke_o(cke), .sd_cs_n_o(cs_n), .sd_ras_n_o(ras_n), .sd_cas_n_o(cas_n),
    .sd_we_n_o(we_n), .sd_ba_o(ba), .sd_a_o(a), .sd_dqm_o(dqm),
    .sd_dq_o(dq_out), .sd_dq_oe_o(dq_oe), .sd_dq_i(dq_drv)
  );

  int errors = 0, checks = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- memory bus model ----------------
  longint cyc = 0;
  longint last_act = -1000, last_ref = -1000, last_pre = -1000, last_mrs = -1000;
  longint pre_ready = -1000, first_cmd = -1;
  bit     row_open = 0, pre_all_open = 0;
  logic [1:0]  open_bank;
  logic [11:0] open_row;
  int     ref_count = 0, ev_n = 0;
  logic [3:0] ev_cmd [4];
  logic [11:0] ev_a [4];
  longint ev_cyc [4];
  logic [7:0] mem [int];
  bit rd_pend = 0;
  logic [7:0] rd_data;

  function automatic longint lmax(input longint x, input longint y);
    return (x > y) ? x : y;
  endfunction

  always @(posedge clk) begin
    logic [3:0] c;
    int key;
    if (rst_n) begin
      cyc = cyc + 1;
      if (rd_pend) begin dq_drv <= rd_data; rd_pend = 0; end
      c = {cs_n, ras_n, cas_n, we_n};
      if (c != 4'b0111 && c[3] == 1'b0 && ev_n < 4) begin
        ev_cmd[ev_n] = c; ev_a[ev_n] = a; ev_cyc[ev_n] = cyc; ev_n++;
      end
      if (c != 4'b0111 && c[3] == 1'b0 && first_cmd < 0) first_cmd = cyc;
      if (dq_oe && c != 4'b0100) check(0, "R5", "dq_oe without WRITE", 1, 0);
      unique case (c)
        4'b0011: begin // ACT
          check(!row_open && cyc >= pre_ready, "R4", "ACT before bank idle", cyc, pre_ready);
          check(cyc - last_act >= TRC, "R4", "ACT to ACT gap", cyc - last_act, TRC);
          check(cyc - last_ref >= TRFC, "R7", "REF to ACT gap", cyc - last_ref, TRFC);
          check(cyc - last_mrs >= TMRD, "R2", "MRS to ACT gap", cyc - last_mrs, TMRD);
          check(!pre_all_open, "R8", "ACT inside refresh precharge", 1, 0);
          row_open = 1; open_bank = ba; open_row = a; last_act = cyc;
        end
        4'b0100, 4'b0101: begin // WR / RD
          check(row_open && ba == open_bank, "R3", "column cmd bank", ba, open_bank);
          check(cyc - last_act == TRCD, "R3", "ACT to column gap", cyc - last_act, TRCD);
          check(a[10] == 1'b1, "R3", "auto-precharge bit", a[10], 1);
          key = {open_bank, open_row, a[8:0]};
          if (c == 4'b0100) begin
            check(dq_oe == 1'b1, "R5", "dq_oe on WRITE", dq_oe, 1);
            mem[key] = dq_out;
          end else begin
            rd_data = mem.exists(key) ? mem[key] : 8'h00;
            rd_pend = 1;
          end
          pre_ready = lmax(cyc + 1, last_act + TRAS) + TRP;
          row_open = 0;
        end
        4'b0010: begin // PRE
          if (a[10]) pre_all_open = 1;
          row_open = 0; pre_ready = lmax(pre_ready, cyc + TRP); last_pre = cyc;
        end
        4'b0001: begin // REF
          check(!row_open && cyc >= pre_ready, "R7", "REF with bank busy", cyc, pre_ready);
          check(cyc - last_ref >= TRFC, "R7", "REF to REF minimum", cyc - last_ref, TRFC);
          if (ref_count >= 2) begin
            check(cyc - last_pre == TRP, "R7", "PRE-all to REF gap", cyc - last_pre, TRP);
            check(cyc - last_ref <= REFI + 20, "R7", "refresh spacing", cyc - last_ref, REFI + 20);
          end
          pre_all_open = 0; ref_count++; last_ref = cyc;
        end
        4'b0000: begin // MRS
          check(a == 12'h020, "R2", "mode word", a, 12'h020);
          check(ref_count >= 2 && cyc - last_ref >= TRFC, "R2", "MRS after refreshes",
                ref_count, 2);
          pre_all_open = 0; last_mrs = cyc;
        end
        default: ;
      endcase
    end
  end

  // ---------------- scenario tasks ----------------
  task automatic issue(input bit wr, input logic [1:0] bk, input logic [11:0] rw,
                       input logic [8:0] cl, input logic [7:0] d, output longint acc);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_bank = bk; req_row = rw; req_col = cl; req_wdata = d;
    while (!req_ready) @(negedge clk);
    acc = cyc + 1;
    @(negedge clk);
    req_valid = 0;
    check(!req_ready, "R9", "ready after accept", req_ready, 0);
  endtask

  task automatic do_write(input logic [1:0] bk, input logic [11:0] rw,
                          input logic [8:0] cl, input logic [7:0] d);
    longint acc;
    issue(1, bk, rw, cl, d, acc);
  endtask

  task automatic do_read(input logic [1:0] bk, input logic [11:0] rw,
                         input logic [8:0] cl, input logic [7:0] exp);
    longint acc, got;
    got = -1;
    issue(0, bk, rw, cl, 8'h00, acc);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (rsp_valid) begin got = cyc; break; end
    end
    check(got == acc + 6, "R6", "read latency edge", got, acc + 6);
    check(rsp_rdata == exp, "R6", "read data", rsp_rdata, exp);
    @(negedge clk);
    check(!rsp_valid, "R6", "single-cycle strobe", rsp_valid, 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(!req_ready && !cke && cs_n && dqm && !dq_oe, "R1", "pins in reset",
          {req_ready, cke, cs_n, dqm, dq_oe}, 5'b00110);
  endtask

  task automatic t_init;
    longint ready_at;
    @(negedge clk) rst_n = 1;
    ready_at = -1;
    for (int i = 0; i < INIT + 200; i++) begin
      @(negedge clk);
      if (req_ready) begin ready_at = cyc; break; end
    end
    check(ready_at > 0 && ev_n == 4, "R2", "init finished", ev_n, 4);
    check(ev_cmd[0] == 4'b0010 && ev_a[0][10], "R2", "first PRE-all", ev_cmd[0], 4'b0010);
    check(ev_cmd[1] == 4'b0001 && ev_cmd[2] == 4'b0001, "R2", "two refreshes",
          {ev_cmd[1], ev_cmd[2]}, 8'h11);
    check(ev_cmd[3] == 4'b0000, "R2", "mode set last", ev_cmd[3], 0);
    check(ev_cyc[0] >= INIT, "R2", "power-up wait", ev_cyc[0], INIT);
    check(ev_cyc[1] - ev_cyc[0] >= TRP && ev_cyc[2] - ev_cyc[1] >= TRFC,
          "R2", "init gaps", ev_cyc[2] - ev_cyc[1], TRFC);
    check(ready_at >= ev_cyc[3], "R2", "ready after mode set", ready_at, ev_cyc[3]);
    check(cke && !dqm, "R1", "cke up, dqm released", {cke, dqm}, 2'b10);
  endtask

  task automatic t_rw_patterns;
    do_write(2'd0, 12'h000, 9'h000, 8'hA5);
    do_write(2'd3, 12'hFFF, 9'h1FF, 8'h5A);
    do_write(2'd1, 12'h123, 9'h045, 8'h3C);
    do_write(2'd2, 12'h123, 9'h045, 8'hC3);
    do_read(2'd0, 12'h000, 9'h000, 8'hA5);
    do_read(2'd3, 12'hFFF, 9'h1FF, 8'h5A);
    do_read(2'd1, 12'h123, 9'h045, 8'h3C);
    do_read(2'd2, 12'h123, 9'h045, 8'hC3);
    do_write(2'd1, 12'h123, 9'h045, 8'h00);
    do_read(2'd1, 12'h123, 9'h045, 8'h00);
  endtask

  task automatic t_back_to_back;
    longint a1, a2;
    a1 = -1; a2 = -1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = 1; req_bank = 2'd2; req_row = 12'h0AA; req_col = 9'h011;
    req_wdata = 8'h11;
    for (int i = 0; i < 40 && a2 < 0; i++) begin
      if (req_ready) begin
        if (a1 < 0) a1 = cyc + 1; else a2 = cyc + 1;
        @(negedge clk);
        check(!req_ready, "R9", "ready drops after accept", req_ready, 0);
        req_row = 12'h0AB; req_wdata = 8'h22;
      end else @(negedge clk);
    end
    req_valid = 0;
    check(a2 - a1 == TRC, "R4", "back-to-back accept spacing", a2 - a1, TRC);
    do_read(2'd2, 12'h0AA, 9'h011, 8'h11);
    do_read(2'd2, 12'h0AB, 9'h011, 8'h22);
  endtask

  task automatic t_idle_refresh;
    int r0;
    r0 = ref_count;
    repeat (3 * REFI + 40) @(negedge clk);
    check(ref_count - r0 >= 3, "R7", "refreshes while idle", ref_count - r0, 3);
  endtask

  task automatic t_stream_refresh;
    int r0;
    longint t0;
    r0 = ref_count; t0 = cyc;
    for (int n = 0; cyc - t0 < 2 * REFI + 60; n++)
      do_write(2'(n), 12'(n), 9'(n * 3), 8'(n ^ 8'h5C));
    check(ref_count - r0 >= 2, "R8", "refresh under traffic", ref_count - r0, 2);
    do_read(2'd1, 12'd5, 9'd15, 8'(5 ^ 8'h5C));
  endtask

  initial begin
    t_reset();
    t_init();
    t_rw_patterns();
    t_back_to_back();
    t_idle_refresh();
    t_stream_refresh();
    repeat (5) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 150000, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule